// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management frames towards external PHY devices. A host programs it over a plain 32-bit register bus that is always ready: an address, a write strobe, write data, and read data decoded combinationally from the address. A frame starts when the host writes the write-data register, or when it sets the read bit of the command register from 0 to 1. A scan mode re-reads one PHY register with no gaps for as long as the scan bit stays set. The host polls an indicator register for busy, scan and not-valid. A spare register holds the address of the on-chip TBI PHY.

The serial clock is a divided copy of the system clock, and a 4-bit code selects the ratio. The management data line is split into an output, an output enable and an input. A frame engine built around three states sequences each frame. In `ENG_IDLE` the line is released and the clock is held low. A start moves the engine to `ENG_PREAMBLE`, or straight to `ENG_BODY` when the preamble is suppressed. The 32nd falling edge of the serial clock takes `ENG_PREAMBLE` to `ENG_BODY`, and the 32nd falling edge in `ENG_BODY` returns the engine to `ENG_IDLE`. A soft reset sends the engine from any state back to `ENG_IDLE`.

Top module: `mdio_mgr`

## Requirements
- R1: After reset, every indicator flag reads 0, the serial clock and the output enable are low, the status register reads 0, and the TBI address register (offset 0x34, bits [4:0]) reads 0x1F.
- R2: Configuration bits [3:0] (offset 0x00) set the serial clock period in system clocks: codes 0..7 give 2, 4, 6, 8, 10, 14, 20, 28, and codes 8..15 give 16, 32, 48, 64, 80, 112, 160, 224. The duty cycle is 50 %.
- R3: A write frame is sent MSB first: 32 ones, then 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 driven by the master, and 16 data bits. The PHY address comes from bits [12:8] of the address register (0x08) and the register number from bits [4:0].
- R4: Writing the control register (0x0C) starts a write frame that sends bits [15:0]. Indicator bit 0 (offset 0x14) is 1 from the next cycle until the frame ends.
- R5: A read frame starts only when a bus write moves command bit 0 (offset 0x04) from 0 to 1. Writing a 1 while the bit already holds 1 starts nothing.
- R6: A read frame uses opcode 10. The output enable is low for the whole turnaround and for all 16 data bits. The data bits are sampled MSB first and placed in status register bits [15:0] (offset 0x10).
- R7: Indicator bit 2 (not-valid) is 1 from the cycle after a read starts until the read data are written to the status register, and then returns to 0.
- R8: Configuration bit 4 suppresses the preamble, so the frame begins with the start code.
- R9: While command bit 1 is 1, read frames of the addressed register repeat, and indicator bit 1 reads 1. Once the bit is cleared, no new frame starts after the one in flight.
- R10: While configuration bit 31 is 1, a frame in flight is aborted. Busy and not-valid read 0, the serial clock and the output enable are low, and the status register keeps its old value. The command register is cleared.
- R11: A start request (a control write or a 0-to-1 edge of the read bit) that arrives while a frame runs is dropped. The running frame completes with its original data.
- R12: The data output changes only on a falling edge of the serial clock, and input bits are sampled on its rising edge. The serial clock idles low, and the output enable is low whenever no frame runs.
- R13: The TBI address register keeps bits [4:0] of a write and reads 0 in bits [31:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data input |

## Verification
The collision that matters is a new start request that arrives while a frame is still running. A frame end can also meet a scan restart or a command change in the same cycle. The bench writes the control register a second time during a write frame, and it raises the read bit in the middle of that frame. It then checks that the PHY model saw exactly one frame and that this frame carried the first data word, with no not-valid flag left behind. A second collision is a soft reset that lands while a read is half done. That case is judged by an idle indicator, a low clock and output enable, and a status register that still holds its previous value.

// File: rtl/mdio_mgr_pkg.sv
`timescale 1ns/1ps
package mdio_mgr_pkg;
    localparam int BUS_W      = 32;
    localparam int DIV_CODE_W = 4;
    localparam int HALF_W     = 7;
    localparam int FIELD_W    = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 32;

    localparam int OFS_CFG  = 'h00;
    localparam int OFS_CMD  = 'h04;
    localparam int OFS_ADR  = 'h08;
    localparam int OFS_WDAT = 'h0C;
    localparam int OFS_RDAT = 'h10;
    localparam int OFS_FLAG = 'h14;
    localparam int OFS_TBI  = 'h34;

    typedef enum logic [1:0] {
        ENG_IDLE     = 2'd0,
        ENG_PREAMBLE = 2'd1,
        ENG_BODY     = 2'd2
    } eng_state_e;

    // half of the serial clock period, in system clocks, per divider code
    function automatic logic [HALF_W-1:0] half_period(input logic [DIV_CODE_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            4'd0:    h = 7'd1;
            4'd1:    h = 7'd2;
            4'd2:    h = 7'd3;
            4'd3:    h = 7'd4;
            4'd4:    h = 7'd5;
            4'd5:    h = 7'd7;
            4'd6:    h = 7'd10;
            4'd7:    h = 7'd14;
            4'd8:    h = 7'd8;
            4'd9:    h = 7'd16;
            4'd10:   h = 7'd24;
            4'd11:   h = 7'd32;
            4'd12:   h = 7'd40;
            4'd13:   h = 7'd56;
            4'd14:   h = 7'd80;
            default: h = 7'd112;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/mdio_mgr_clkdiv.sv
`timescale 1ns/1ps
module mdio_mgr_clkdiv
    import mdio_mgr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [DIV_CODE_W-1:0] code,
    output logic                  mdc,
    output logic                  rise,
    output logic                  fall
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;
    logic              tc;

    always_comb begin
        half = half_period(code);
        tc   = en && (cnt_q >= half - 1'b1);
        rise = tc && !mdc;
        fall = tc && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tc) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the serial clock holds its level between terminal counts
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise && !fall) |=> $stable(mdc));
endmodule

// File: rtl/mdio_mgr_engine.sv
`timescale 1ns/1ps
module mdio_mgr_engine
    import mdio_mgr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic               is_read,
    input  logic               no_pre,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regn,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               active,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int CNT_W  = $clog2(BODY_BITS);
    localparam int TA_POS = DATA_W + 1;

    eng_state_e             state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [BODY_BITS-1:0]   shift_q;
    logic                   rd_q;
    logic [DATA_W-1:0]      cap_q;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
        end else if (abort) begin
            state_q <= ENG_IDLE;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        shift_q <= {2'b01, (is_read ? 2'b10 : 2'b01), phy, regn,
                                    (is_read ? 2'b11 : 2'b10),
                                    (is_read ? {DATA_W{1'b1}} : wdata)};
                        rd_q    <= is_read;
                        cnt_q   <= no_pre ? CNT_W'(BODY_BITS - 1) : CNT_W'(PRE_BITS - 1);
                        state_q <= no_pre ? ENG_BODY : ENG_PREAMBLE;
                    end
                end
                ENG_PREAMBLE: begin
                    if (fall) begin
                        if (cnt_q == '0) begin
                            state_q <= ENG_BODY;
                            cnt_q   <= CNT_W'(BODY_BITS - 1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ENG_BODY: begin
                    if (rise && rd_q && cnt_q <= CNT_W'(DATA_W - 1))
                        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
                    if (fall) begin
                        if (cnt_q == '0) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            shift_q <= {shift_q[BODY_BITS-2:0], 1'b0};
                            cnt_q   <= cnt_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        active  = (state_q != ENG_IDLE);
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ENG_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ENG_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ENG_BODY: begin
                mdio_o  = shift_q[BODY_BITS-1];
                mdio_oe = !(rd_q && cnt_q <= CNT_W'(TA_POS));
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
        rd_done = (state_q == ENG_BODY) && fall && (cnt_q == '0) && rd_q && !abort;
        rd_data = cap_q;
    end

    // R12: the output bit moves only on a falling edge of the serial clock
    a_r12_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(fall) && !$past(abort)) |-> $stable(mdio_o));

    // R6: every sampled read bit comes while the line is released
    a_r6_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && rd_q && state_q == ENG_BODY && cnt_q <= CNT_W'(DATA_W - 1)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgr.sv
`timescale 1ns/1ps
module mdio_mgr
    import mdio_mgr_pkg::*;
#(
    parameter int                 AW        = 8,
    parameter logic [FIELD_W-1:0] TBI_RESET = 5'h1F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic                  cfg_rst_q, cfg_nopre_q;
    logic [DIV_CODE_W-1:0] cfg_div_q;
    logic [1:0]            cmd_q;
    logic [FIELD_W-1:0]    phy_q, reg_q, tbi_q;
    logic [DATA_W-1:0]     wdat_q, rdat_q, eng_rdata;
    logic                  nv_q;
    logic                  hit_cfg, hit_cmd, hit_adr, hit_wdat, hit_tbi;
    logic                  write_req, read_req, scan_req, start, is_read;
    logic                  eng_active, eng_done, eng_abort, div_en, tick_rise, tick_fall;
    logic                  unused_bits;

    assign unused_bits = &{1'b0, bus_wdata[30:16]};

    always_comb begin
        hit_cfg   = bus_we && (bus_addr == AW'(OFS_CFG));
        hit_cmd   = bus_we && (bus_addr == AW'(OFS_CMD));
        hit_adr   = bus_we && (bus_addr == AW'(OFS_ADR));
        hit_wdat  = bus_we && (bus_addr == AW'(OFS_WDAT));
        hit_tbi   = bus_we && (bus_addr == AW'(OFS_TBI));
        write_req = hit_wdat && !eng_active && !cfg_rst_q;
        read_req  = hit_cmd && bus_wdata[0] && !cmd_q[0] && !eng_active && !cfg_rst_q;
        scan_req  = cmd_q[1] && !eng_active && !cfg_rst_q;
        start     = write_req || read_req || scan_req;
        is_read   = !write_req;
        eng_abort = cfg_rst_q;
        div_en    = eng_active && !eng_abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rst_q   <= 1'b0;
            cfg_nopre_q <= 1'b0;
            cfg_div_q   <= '0;
            cmd_q       <= '0;
            phy_q       <= '0;
            reg_q       <= '0;
            wdat_q      <= '0;
            rdat_q      <= '0;
            nv_q        <= 1'b0;
            tbi_q       <= TBI_RESET;
        end else begin
            if (hit_cfg) begin
                cfg_rst_q   <= bus_wdata[31];
                cfg_nopre_q <= bus_wdata[4];
                cfg_div_q   <= bus_wdata[DIV_CODE_W-1:0];
            end
            if (cfg_rst_q)    cmd_q <= '0;
            else if (hit_cmd) cmd_q <= bus_wdata[1:0];
            if (hit_adr) begin
                phy_q <= bus_wdata[8 +: FIELD_W];
                reg_q <= bus_wdata[0 +: FIELD_W];
            end
            if (hit_wdat) wdat_q <= bus_wdata[DATA_W-1:0];
            if (hit_tbi)  tbi_q  <= bus_wdata[FIELD_W-1:0];
            if (eng_done) rdat_q <= eng_rdata;
            if (cfg_rst_q || eng_done)  nv_q <= 1'b0;
            else if (start && is_read)  nv_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_CFG):  bus_rdata = {cfg_rst_q, 26'd0, cfg_nopre_q, cfg_div_q};
            AW'(OFS_CMD):  bus_rdata = {30'd0, cmd_q};
            AW'(OFS_ADR):  bus_rdata = {19'd0, phy_q, 3'd0, reg_q};
            AW'(OFS_WDAT): bus_rdata = {16'd0, wdat_q};
            AW'(OFS_RDAT): bus_rdata = {16'd0, rdat_q};
            AW'(OFS_FLAG): bus_rdata = {29'd0, nv_q, cmd_q[1], eng_active};
            AW'(OFS_TBI):  bus_rdata = {27'd0, tbi_q};
            default:       bus_rdata = '0;
        endcase
    end

    mdio_mgr_clkdiv u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (div_en),
        .code (cfg_div_q),
        .mdc  (mdc),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    mdio_mgr_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (eng_abort),
        .start  (start),
        .is_read(is_read),
        .no_pre (cfg_nopre_q),
        .phy    (phy_q),
        .regn   (reg_q),
        .wdata  (bus_wdata[DATA_W-1:0]),
        .rise   (tick_rise),
        .fall   (tick_fall),
        .mdio_i (mdio_i),
        .active (eng_active),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .rd_done(eng_done),
        .rd_data(eng_rdata)
    );

    // R7: not-valid only while a frame is running
    a_r7_nv_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q |-> eng_active);

    // R10: soft reset leaves the engine idle and the flag clear
    a_r10_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_q |=> (!eng_active && !nv_q));

    // R4: an accepted control write makes the block busy
    a_r4_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        write_req |=> eng_active);

    // R12: the serial clock rests low whenever no frame runs
    a_r12_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_active |-> !mdc);
endmodule

// File: tb/mdio_mgr_bench.sv
`timescale 1ns/1ps
module mdio_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_mgr u_mdio_mgr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY model ----------------
    logic [15:0] phy_word = '0;
    logic        m_in = 1'b0;
    int          m_n = 0, m_ones = 0, m_pre = 0;
    logic [12:0] m_hdr = '0;
    logic [1:0]  m_ta = '0, m_taoe = '0;
    logic [15:0] m_dat = '0;
    logic        m_doe = 1'b0;
    int          frames = 0, f_pre = 0;
    logic [1:0]  f_op, f_ta, f_taoe;
    logic [4:0]  f_phy, f_reg;
    logic [15:0] f_dat;
    logic        f_doe;

    always @(posedge mdc) begin
        if (!m_in) begin
            if (mdio_oe && !mdio_o) begin
                m_in = 1'b1; m_n = 1; m_pre = m_ones; m_ones = 0; m_doe = 1'b0;
            end else if (mdio_oe) begin
                m_ones++;
            end
        end else begin
            if (m_n <= 13) m_hdr = {m_hdr[11:0], mdio_o};
            else if (m_n <= 15) begin
                m_ta = {m_ta[0], mdio_o}; m_taoe = {m_taoe[0], mdio_oe};
            end else begin
                m_dat = {m_dat[14:0], mdio_o}; m_doe = m_doe | mdio_oe;
            end
            m_n++;
            if (m_n == 32) begin
                m_in = 1'b0; frames++;
                f_op = m_hdr[11:10]; f_phy = m_hdr[9:5]; f_reg = m_hdr[4:0];
                f_ta = m_ta; f_taoe = m_taoe; f_dat = m_dat; f_doe = m_doe; f_pre = m_pre;
            end
        end
        mdio_i = (m_in && m_hdr[11:10] == 2'b10 && m_n >= 16 && m_n <= 31) ? phy_word[31-m_n] : 1'b1;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40000; i++) begin
            bus_read(8'h14, v);
            if (!v[0]) break;
        end
    endtask

    task automatic measure(output int per);
        time t0, t1;
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        per = int'((t1 - t0) / 4);
    endtask

    // {4'b0, read, nopre, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [31:0] VEC [6] = '{
        {4'h0, 1'b0, 1'b0, 5'h01, 5'h00, 16'h1234},
        {4'h0, 1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF},
        {4'h0, 1'b1, 1'b0, 5'h05, 5'h02, 16'hA5C3},
        {4'h0, 1'b1, 1'b1, 5'h10, 5'h11, 16'h0001},
        {4'h0, 1'b0, 1'b0, 5'h00, 5'h0A, 16'h8000},
        {4'h0, 1'b1, 1'b0, 5'h1F, 5'h00, 16'h7E00}
    };

    localparam int DCODE [4] = '{0, 5, 8, 13};
    localparam int DPER  [4] = '{2, 14, 16, 112};

    initial begin : watchdog
        #800000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [15:0] exp_rdat;
        int f0, per;
        exp_rdat = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h14, v); chk(v == 0, "R1 indicator", v, 0);
        bus_read(8'h34, v); chk(v == 32'h1F, "R1 tbi reset", v, 32'h1F);
        bus_read(8'h10, v); chk(v == 0, "R1 status", v, 0);
        chk(mdc == 0 && mdio_oe == 0, "R1 mdc/oe low", {mdc, mdio_oe}, 0);

        // table of frames
        for (int k = 0; k < 6; k++) begin
            logic rd, np;
            logic [4:0] ph, rg;
            logic [15:0] dt;
            rd = VEC[k][27]; np = VEC[k][26]; ph = VEC[k][25:21]; rg = VEC[k][20:16]; dt = VEC[k][15:0];
            bus_write(8'h00, {27'd0, np, 4'd0});
            bus_write(8'h08, {19'd0, ph, 3'd0, rg});
            f0 = frames;
            if (rd) begin
                phy_word = dt;
                bus_write(8'h04, 0);
                bus_write(8'h04, 1);
                bus_read(8'h14, v); chk(v == 32'h5, "R7 nv+busy during read", v, 5);
            end else begin
                bus_write(8'h0C, {16'd0, dt});
                bus_read(8'h14, v); chk(v[0] == 1'b1, "R4 busy during write", v, 1);
            end
            wait_idle();
            chk(frames == f0 + 1, "R4/R5 one frame", frames, f0 + 1);
            chk(f_pre == (np ? 0 : 32), np ? "R8 no preamble" : "R3 preamble 32", f_pre, np ? 0 : 32);
            chk(f_op == (rd ? 2'b10 : 2'b01), rd ? "R6 opcode" : "R3 opcode", f_op, rd ? 2 : 1);
            chk(f_phy == ph && f_reg == rg, "R3 address fields", {f_phy, f_reg}, {ph, rg});
            if (rd) begin
                chk(f_taoe == 2'b00 && f_doe == 1'b0, "R6 released line", {f_taoe, f_doe}, 0);
                bus_read(8'h10, v); chk(v == {16'd0, dt}, "R6 status data", v, dt);
                exp_rdat = dt;
                bus_read(8'h14, v); chk(v == 0, "R7 nv cleared", v, 0);
            end else begin
                chk(f_ta == 2'b10 && f_taoe == 2'b11, "R3 turnaround", {f_taoe, f_ta}, 4'b1110);
                chk(f_dat == dt, "R3 write data", f_dat, dt);
            end
            chk(mdc == 0 && mdio_oe == 0, "R12 idle lines", {mdc, mdio_oe}, 0);
        end

        // R2 divider ratios
        for (int k = 0; k < 4; k++) begin
            bus_write(8'h00, DCODE[k]);
            bus_write(8'h0C, 32'h0000_5555);
            measure(per);
            chk(per == DPER[k], "R2 mdc period", per, DPER[k]);
            wait_idle();
        end
        bus_write(8'h00, 0);

        // R5 re-writing read bit while already set
        bus_write(8'h04, 0);
        phy_word = 16'h0F0F;
        bus_write(8'h04, 1);
        wait_idle();
        exp_rdat = 16'h0F0F;
        f0 = frames;
        bus_write(8'h04, 1);
        repeat (300) @(negedge clk);
        chk(frames == f0, "R5 no frame without edge", frames, f0);
        bus_read(8'h14, v); chk(v == 0, "R5 stays idle", v, 0);

        // R11 start requests while busy
        f0 = frames;
        bus_write(8'h04, 0);
        bus_write(8'h0C, 32'h0000_1111);
        repeat (10) @(negedge clk);
        bus_write(8'h0C, 32'h0000_2222);
        bus_write(8'h04, 1);
        wait_idle();
        repeat (300) @(negedge clk);
        chk(frames == f0 + 1, "R11 single frame", frames, f0 + 1);
        chk(f_dat == 16'h1111, "R11 original data", f_dat, 16'h1111);
        bus_read(8'h14, v); chk(v == 0, "R11 no nv left", v, 0);

        // R9 scan
        bus_write(8'h04, 0);
        bus_write(8'h00, 32'h10);
        phy_word = 16'h3C3C;
        f0 = frames;
        bus_write(8'h04, 2);
        for (int i = 0; i < 5000 && frames < f0 + 3; i++) @(negedge clk);
        chk(frames >= f0 + 3, "R9 repeated reads", frames, f0 + 3);
        chk(f_op == 2'b10, "R9 read opcode", f_op, 2);
        bus_read(8'h14, v); chk(v[1] == 1'b1, "R9 scan flag", v, 2);
        bus_write(8'h04, 0);
        wait_idle();
        f0 = frames;
        repeat (300) @(negedge clk);
        chk(frames == f0, "R9 scan stopped", frames, f0);
        bus_read(8'h10, v); chk(v == 32'h3C3C, "R9 status", v, 32'h3C3C);
        exp_rdat = 16'h3C3C;
        bus_read(8'h14, v); chk(v == 0, "R9 flags clear", v, 0);

        // R10 soft reset during a slow read
        bus_write(8'h00, 32'h0000_000D);
        phy_word = 16'hDEAD;
        bus_write(8'h04, 1);
        repeat (400) @(negedge clk);
        bus_write(8'h00, 32'h8000_000D);
        bus_read(8'h14, v); chk(v == 0, "R10 flags cleared", v, 0);
        chk(mdc == 0 && mdio_oe == 0, "R10 lines low", {mdc, mdio_oe}, 0);
        bus_read(8'h04, v); chk(v == 0, "R10 command cleared", v, 0);
        bus_read(8'h10, v); chk(v == {16'd0, exp_rdat}, "R10 status kept", v, exp_rdat);
        bus_write(8'h00, 0);
        m_in = 1'b0; m_ones = 0; m_n = 0;
        f0 = frames;
        bus_write(8'h0C, 32'h0000_ABCD);
        wait_idle();
        chk(frames == f0 + 1 && f_dat == 16'hABCD, "R10 works after abort", f_dat, 16'hABCD);

        // R13 TBI register
        bus_write(8'h34, 32'hFFFF_FFE7);
        bus_read(8'h34, v); chk(v == 32'h07, "R13 tbi field", v, 32'h07);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule